// File: doc/BRIEF.md
# Dual-channel IQ gain and offset stage

This block sits just before a dual DAC. It takes a pair of signed 16-bit sample streams, I and Q, that arrive together on one valid/data interface. It scales each stream by its own unsigned fixed-point gain and then adds a signed DC offset for that channel. Each result is rounded to an integer and clamped to the signed 16-bit range. The two results leave on separate valid/data outputs.

Gains and offsets are held in two packed configuration words. These are written and read back through a small address/data port. A gain code of exactly one bypasses that channel's multiplier, which gives it a shorter pipeline than the other channel. When the two channels use different settings, their outputs are therefore skewed by one cycle.

Top module: `iq_gain_offset`

## Requirements
- R1: After reset, both gain codes are 0x080, both offsets are 0 and both output valids are low. A read of address 0x0C returns 0x00010080 and a read of address 0x0D returns 0.
- R2: Address 0x0C holds the gain word: I gain in bits [8:0], Q gain in bits [17:9], and bits [31:18] always read 0. Address 0x0D holds the offset word: I offset in bits [15:0] and Q offset in bits [31:16]. Any other address reads 0, and a write to it changes neither word.
- R3: A gain code g is unsigned, with bit 8 weighing 2 and bit 0 weighing 1/128. For an input x and an offset o, the output is floor((x*g + 64) / 128) + o. The 0.5 tie therefore rounds toward plus infinity.
- R4: The result saturates to the range -32768 to 32767 and never wraps. This includes gain 0x1FF with full-scale inputs of either sign.
- R5: When the gain code is not 0x080, a sample presented in cycle t appears on that channel's output in cycle t+2.
- R6: When the gain code is 0x080, the multiplier is bypassed and the sample appears in cycle t+1. The exception is a multiply-path sample still in flight for that channel: then the sample takes cycle t+2, so samples are never dropped or reordered.
- R7: Each channel raises its own output valid at its own latency. With I at a non-unity gain and Q at 0x080, Q leads I by one cycle.
- R8: A configuration write takes effect from the sample presented in the cycle after the write. A sample presented in the cycle of the write, and any sample already in the pipeline, uses the old values.
- R9: A gain code of 0 makes the output equal to the channel's offset, whatever the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 8 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational on cfg_addr) |
| in_valid | input | 1 | An I/Q sample pair is present |
| in_i | input | 16 | I sample, signed |
| in_q | input | 16 | Q sample, signed |
| out_i_valid | output | 1 | I result valid |
| out_i | output | 16 | I result, signed |
| out_q_valid | output | 1 | Q result valid |
| out_q | output | 16 | Q result, signed |

## Verification
On one channel, two events can fall in the same output cycle: a multiply-path sample leaving its second stage, and a unity-gain sample that arrives right behind it and would otherwise take the one-cycle bypass. The bench provokes this by switching a channel's gain to 0x080 in the middle of a continuous stream, and also by random gain writes under random traffic. A behavioural model predicts, for every sample, which cycle it appears in and with what value, and the outputs are compared against it on every clock. A lost, duplicated or early sample shows up as a valid or data mismatch.

// File: rtl/iqgo_pkg.sv
package iqgo_pkg;
   localparam int REG_W  = 32;
   localparam int ADDR_W = 8;
   localparam logic [ADDR_W-1:0] GAIN_WORD_ADDR   = 8'h0C;
   localparam logic [ADDR_W-1:0] OFFSET_WORD_ADDR = 8'h0D;

   typedef enum int {
      CH_I = 0,
      CH_Q = 1
   } chan_e;

   localparam int NUM_CH = 2;
endpackage

// File: rtl/iqgo_cfg_regs.sv
module iqgo_cfg_regs
   import iqgo_pkg::*;
#(
   parameter int SCALE_W = 9,
   parameter int FRAC_W  = 7,
   parameter int OFF_W   = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [REG_W-1:0]         wdata,
   output logic [REG_W-1:0]         rdata,
   output logic [SCALE_W-1:0]       gain_i,
   output logic [SCALE_W-1:0]       gain_q,
   output logic signed [OFF_W-1:0]  offs_i,
   output logic signed [OFF_W-1:0]  offs_q
);
   localparam logic [SCALE_W-1:0] UNITY_CODE = SCALE_W'(1) << FRAC_W;
   localparam int GAIN_PAD = REG_W - 2*SCALE_W;

   logic hit_gain, hit_offs;

   assign hit_gain = (addr == GAIN_WORD_ADDR);
   assign hit_offs = (addr == OFFSET_WORD_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gain_i <= UNITY_CODE;
         gain_q <= UNITY_CODE;
         offs_i <= '0;
         offs_q <= '0;
      end else if (wr_en) begin
         if (hit_gain) begin
            gain_i <= wdata[SCALE_W-1:0];
            gain_q <= wdata[2*SCALE_W-1:SCALE_W];
         end
         if (hit_offs) begin
            offs_i <= wdata[OFF_W-1:0];
            offs_q <= wdata[2*OFF_W-1:OFF_W];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (hit_gain)
         rdata = {{GAIN_PAD{1'b0}}, gain_q, gain_i};
      else if (hit_offs)
         rdata = REG_W'({offs_q, offs_i});
   end

   // R2: a gain write lands in both fields on the next cycle
   p_gain_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit_gain) |=> (gain_i == $past(wdata[SCALE_W-1:0]) &&
                               gain_q == $past(wdata[2*SCALE_W-1:SCALE_W])));

   // R2: writes to any other address leave both words untouched
   p_stray_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !hit_gain && !hit_offs) |=> ($stable(gain_i) && $stable(gain_q) &&
                                             $stable(offs_i) && $stable(offs_q)));
endmodule

// File: rtl/iqgo_channel.sv
module iqgo_channel #(
   parameter int SAMPLE_W     = 16,
   parameter int SCALE_W      = 9,
   parameter int FRAC_W       = 7,
   parameter int OFF_W        = 16,
   parameter bit UNITY_BYPASS = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic signed [SAMPLE_W-1:0]  in_data,
   input  logic [SCALE_W-1:0]          gain,
   input  logic signed [OFF_W-1:0]     offs,
   output logic                        out_valid,
   output logic signed [SAMPLE_W-1:0]  out_data
);
   localparam int PROD_W = SAMPLE_W + SCALE_W + 1;
   localparam int RND_W  = PROD_W + 1;
   localparam int INT_W  = RND_W - FRAC_W;
   localparam int SUM_W  = INT_W + 1;
   localparam logic [SCALE_W-1:0] UNITY_CODE = SCALE_W'(1) << FRAC_W;
   localparam logic signed [SUM_W-1:0] HI_LIM = SUM_W'((64'sd1 <<< (SAMPLE_W-1)) - 1);
   localparam logic signed [SUM_W-1:0] LO_LIM = -HI_LIM - SUM_W'(1);

   if (SUM_W <= OFF_W) begin : g_bad_sum
      $error("iqgo_channel: sum width too narrow for offset");
   end

   function automatic logic signed [PROD_W-1:0] mul_gain(
      input logic signed [SAMPLE_W-1:0] x,
      input logic [SCALE_W-1:0]         k
   );
      logic signed [PROD_W-1:0] kx;
      kx = PROD_W'(signed'({1'b0, k}));
      return PROD_W'(x) * kx;
   endfunction

   function automatic logic signed [SAMPLE_W-1:0] round_add_clip(
      input logic signed [PROD_W-1:0] p,
      input logic signed [OFF_W-1:0]  o
   );
      logic signed [RND_W-1:0] r;
      logic signed [INT_W-1:0] t;
      logic signed [SUM_W-1:0] s;
      r = RND_W'(p) + RND_W'(64'sd1 <<< (FRAC_W-1));
      t = r[RND_W-1:FRAC_W];
      s = SUM_W'(t) + SUM_W'(o);
      if (s > HI_LIM)
         return HI_LIM[SAMPLE_W-1:0];
      else if (s < LO_LIM)
         return LO_LIM[SAMPLE_W-1:0];
      return s[SAMPLE_W-1:0];
   endfunction

   logic                       is_unity;
   logic                       take_direct, take_mul;
   logic                       s1_valid;
   logic signed [PROD_W-1:0]   s1_prod;
   logic signed [OFF_W-1:0]    s1_offs;
   logic signed [PROD_W-1:0]   byp_prod;
   logic [1:0]                 age;

   if (UNITY_BYPASS) begin : g_bypass
      assign is_unity = (gain == UNITY_CODE);
   end else begin : g_no_bypass
      assign is_unity = 1'b0;
   end

   // unity samples skip the multiplier unless an older sample is in flight
   assign take_direct = in_valid && is_unity && !s1_valid;
   assign take_mul    = in_valid && !take_direct;
   assign byp_prod    = PROD_W'(in_data) <<< FRAC_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_prod   <= '0;
         s1_offs   <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         s1_valid <= take_mul;
         if (take_mul) begin
            s1_prod <= mul_gain(in_data, gain);
            s1_offs <= offs;
         end
         out_valid <= s1_valid | take_direct;
         if (s1_valid)
            out_data <= round_add_clip(s1_prod, s1_offs);
         else if (take_direct)
            out_data <= round_add_clip(byp_prod, offs);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         age <= '0;
      else if (age != 2'd3)
         age <= age + 2'd1;
   end

   // R5: a non-unity sample always emerges two cycles later
   p_mul_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && $past(in_valid && !is_unity, 2)) |-> out_valid);

   // R6: a unity sample with nothing in flight emerges one cycle later, unchanged when offset is 0
   p_bypass_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_unity && !s1_valid && offs == '0) |=> (out_valid && out_data == $past(in_data)));

   // R7: a valid output always traces back to an input one or two cycles earlier
   p_valid_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && out_valid) |-> ($past(in_valid) || $past(in_valid, 2)));

   // R9: gain zero yields the captured offset
   p_zero_gain_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && $past(in_valid && gain == '0, 2)) |-> (out_data == SAMPLE_W'($past(offs, 2))));
endmodule

// File: rtl/iq_gain_offset.sv
module iq_gain_offset
   import iqgo_pkg::*;
#(
   parameter int SAMPLE_W     = 16,
   parameter int SCALE_W      = 9,
   parameter int FRAC_W       = 7,
   parameter int OFF_W        = 16,
   parameter bit UNITY_BYPASS = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr_en,
   input  logic [7:0]           cfg_addr,
   input  logic [31:0]          cfg_wdata,
   output logic [31:0]          cfg_rdata,
   input  logic                 in_valid,
   input  logic [15:0]          in_i,
   input  logic [15:0]          in_q,
   output logic                 out_i_valid,
   output logic [15:0]          out_i,
   output logic                 out_q_valid,
   output logic [15:0]          out_q
);
   if (2*SCALE_W > REG_W) begin : g_bad_gain
      $error("iq_gain_offset: gain fields exceed the register width");
   end
   if (2*OFF_W > REG_W) begin : g_bad_offs
      $error("iq_gain_offset: offset fields exceed the register width");
   end
   if (FRAC_W >= SCALE_W || FRAC_W < 1) begin : g_bad_frac
      $error("iq_gain_offset: fraction bits must lie inside the gain code");
   end
   if (OFF_W > SAMPLE_W) begin : g_bad_ow
      $error("iq_gain_offset: offset wider than sample");
   end
   if (SAMPLE_W != 16) begin : g_bad_sw
      $error("iq_gain_offset: port width fixed at 16 bits");
   end

   logic [SCALE_W-1:0]         gain_ch [NUM_CH];
   logic signed [OFF_W-1:0]    offs_ch [NUM_CH];
   logic signed [SAMPLE_W-1:0] din_ch  [NUM_CH];
   logic signed [SAMPLE_W-1:0] dout_ch [NUM_CH];
   logic                       vout_ch [NUM_CH];

   iqgo_cfg_regs #(
      .SCALE_W (SCALE_W),
      .FRAC_W  (FRAC_W),
      .OFF_W   (OFF_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_wr_en),
      .addr   (cfg_addr),
      .wdata  (cfg_wdata),
      .rdata  (cfg_rdata),
      .gain_i (gain_ch[CH_I]),
      .gain_q (gain_ch[CH_Q]),
      .offs_i (offs_ch[CH_I]),
      .offs_q (offs_ch[CH_Q])
   );

   assign din_ch[CH_I] = in_i;
   assign din_ch[CH_Q] = in_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      iqgo_channel #(
         .SAMPLE_W     (SAMPLE_W),
         .SCALE_W      (SCALE_W),
         .FRAC_W       (FRAC_W),
         .OFF_W        (OFF_W),
         .UNITY_BYPASS (UNITY_BYPASS)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_valid  (in_valid),
         .in_data   (din_ch[c]),
         .gain      (gain_ch[c]),
         .offs      (offs_ch[c]),
         .out_valid (vout_ch[c]),
         .out_data  (dout_ch[c])
      );
   end

   assign out_i_valid = vout_ch[CH_I];
   assign out_i       = dout_ch[CH_I];
   assign out_q_valid = vout_ch[CH_Q];
   assign out_q       = dout_ch[CH_Q];

   // R1: outputs stay idle in the cycle right after reset
   p_reset_idle_r1: assert property (@(posedge clk)
      $past(!rst_n) |-> (!out_i_valid && !out_q_valid));
endmodule

// File: tb/sim_iq_gain_offset.sv
module sim_iq_gain_offset;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        in_valid = 1'b0;
   logic [15:0] in_i = '0;
   logic [15:0] in_q = '0;
   logic        out_i_valid, out_q_valid;
   logic [15:0] out_i, out_q;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   int m_gain [2];
   int m_offs [2];
   bit ev [2][8];
   int ed [2][8];

   iq_gain_offset u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
      .in_i(in_i), .in_q(in_q), .out_i_valid(out_i_valid), .out_i(out_i),
      .out_q_valid(out_q_valid), .out_q(out_q)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int ref_out(input int x, input int g, input int o);
      int v;
      v = ((x * g + 64) >>> 7) + o;
      if (v > 32767) v = 32767;
      if (v < -32768) v = -32768;
      return v;
   endfunction

   task automatic report(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic compare_outputs(input string req);
      int s;
      s = cyc % 8;
      report(req, "I valid", int'(out_i_valid), int'(ev[0][s]));
      report(req, "Q valid", int'(out_q_valid), int'(ev[1][s]));
      if (ev[0][s] && out_i_valid) report(req, "I data", int'($signed(out_i)), ed[0][s]);
      if (ev[1][s] && out_q_valid) report(req, "Q data", int'($signed(out_q)), ed[1][s]);
      ev[0][s] = 1'b0;
      ev[1][s] = 1'b0;
   endtask

   task automatic step(input bit iv, input int xi, input int xq, input bit we,
                       input logic [7:0] a, input logic [31:0] wd, input string req);
      int x [2];
      @(negedge clk);
      compare_outputs(req);
      in_valid  = iv;
      in_i      = 16'(xi);
      in_q      = 16'(xq);
      cfg_wr_en = we;
      cfg_addr  = a;
      cfg_wdata = wd;
      x[0] = xi;
      x[1] = xq;
      if (iv) begin
         for (int c = 0; c < 2; c++) begin
            int lat, slot;
            lat = (m_gain[c] == 128 && !ev[c][(cyc + 1) % 8]) ? 1 : 2;
            slot = (cyc + lat) % 8;
            ev[c][slot] = 1'b1;
            ed[c][slot] = ref_out(x[c], m_gain[c], m_offs[c]);
         end
      end
      if (we && a == 8'h0C) begin
         m_gain[0] = int'(wd[8:0]);
         m_gain[1] = int'(wd[17:9]);
      end
      if (we && a == 8'h0D) begin
         m_offs[0] = int'($signed(wd[15:0]));
         m_offs[1] = int'($signed(wd[31:16]));
      end
   endtask

   task automatic idle(input int n, input string req);
      for (int k = 0; k < n; k++) step(1'b0, 0, 0, 1'b0, 8'h00, 32'h0, req);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] wd, input string req);
      step(1'b0, 0, 0, 1'b1, a, wd, req);
   endtask

   task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string req);
      step(1'b0, 0, 0, 1'b0, a, 32'h0, req);
      #1;
      report(req, "readback", int'(cfg_rdata), int'(exp));
   endtask

   function automatic logic [31:0] gains(input int gi, input int gq);
      return {14'h0, 9'(gq), 9'(gi)};
   endfunction

   function automatic logic [31:0] offsets(input int oi, input int oq);
      return {16'(oq), 16'(oi)};
   endfunction

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      m_gain[0] = 128; m_gain[1] = 128;
      m_offs[0] = 0;   m_offs[1] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      report("R1", "I valid in reset", int'(out_i_valid), 0);
      report("R1", "Q valid in reset", int'(out_q_valid), 0);
      rst_n = 1'b1;
      // R1: reset values visible through the register port
      rd_check(8'h0C, 32'h0001_0080, "R1");
      rd_check(8'h0D, 32'h0, "R1");

      // R6: unity on both channels, one-cycle path
      step(1'b1, 1234, -777, 1'b0, 8'h00, 32'h0, "R6");
      idle(3, "R6");

      // R7 and R5: I at gain 2.0, Q at unity, single pair then a burst
      wr(8'h0C, gains(256, 128), "R7");
      step(1'b1, 1000, -1000, 1'b0, 8'h00, 32'h0, "R7");
      idle(3, "R5");
      for (int k = 0; k < 6; k++) step(1'b1, 100 * k - 250, 37 * k, 1'b0, 8'h00, 32'h0, "R7");
      idle(3, "R5");

      // R2: reserved bits drop, fields read back, stray address ignored
      wr(8'h0C, 32'hFFFC_0000 | gains(9'h1FF, 9'h0C1), "R2");
      rd_check(8'h0C, gains(9'h1FF, 9'h0C1), "R2");
      wr(8'h0D, 32'h8000_7FFF, "R2");
      rd_check(8'h0D, 32'h8000_7FFF, "R2");
      wr(8'h0B, 32'hDEAD_BEEF, "R2");
      rd_check(8'h0B, 32'h0, "R2");
      rd_check(8'h0C, gains(9'h1FF, 9'h0C1), "R2");
      rd_check(8'h0D, 32'h8000_7FFF, "R2");

      // R4: maximum gain with full-scale inputs and extreme offsets
      wr(8'h0C, gains(9'h1FF, 9'h1FF), "R4");
      wr(8'h0D, offsets(0, 0), "R4");
      step(1'b1, 32767, -32768, 1'b0, 8'h00, 32'h0, "R4");
      step(1'b1, -32768, 32767, 1'b0, 8'h00, 32'h0, "R4");
      step(1'b1, 8000, -8000, 1'b0, 8'h00, 32'h0, "R4");
      idle(2, "R4");
      wr(8'h0D, offsets(32767, -32768), "R4");
      step(1'b1, 100, -5, 1'b0, 8'h00, 32'h0, "R4");
      step(1'b1, -32768, 32767, 1'b0, 8'h00, 32'h0, "R4");
      idle(3, "R4");

      // R3: rounding ties and fractional gains
      wr(8'h0D, offsets(0, 0), "R3");
      wr(8'h0C, gains(9'h040, 9'h0C1), "R3");
      step(1'b1, 1, 1, 1'b0, 8'h00, 32'h0, "R3");
      step(1'b1, -1, -1, 1'b0, 8'h00, 32'h0, "R3");
      step(1'b1, 3, 255, 1'b0, 8'h00, 32'h0, "R3");
      step(1'b1, -3, -255, 1'b0, 8'h00, 32'h0, "R3");
      for (int k = 0; k < 20; k++)
         step(1'b1, int'($signed(16'($urandom))), int'($signed(16'($urandom))), 1'b0, 8'h00, 32'h0, "R3");
      idle(3, "R3");

      // R9: zero gain yields the offset
      wr(8'h0C, gains(0, 0), "R9");
      wr(8'h0D, offsets(123, -456), "R9");
      for (int k = 0; k < 8; k++)
         step(1'b1, int'($signed(16'($urandom))), int'($signed(16'($urandom))), 1'b0, 8'h00, 32'h0, "R9");
      idle(3, "R9");

      // R6: unity written mid-stream behind a multiply-path sample
      wr(8'h0D, offsets(10, -20), "R6");
      wr(8'h0C, gains(256, 256), "R6");
      for (int k = 0; k < 12; k++) begin
         if (k == 4)
            step(1'b1, 50 * k, -40 * k, 1'b1, 8'h0C, gains(128, 300), "R6");
         else if (k == 8)
            step(1'b1, 50 * k, -40 * k, 1'b1, 8'h0C, gains(128, 128), "R6");
         else
            step(1'b1, 50 * k, -40 * k, 1'b0, 8'h00, 32'h0, "R6");
      end
      idle(2, "R6");
      step(1'b1, 77, 88, 1'b0, 8'h00, 32'h0, "R6");
      idle(3, "R6");

      // R8: writes in the same cycle as streaming samples
      for (int k = 0; k < 40; k++) begin
         bit w;
         logic [7:0] a;
         logic [31:0] d;
         w = (k % 3 == 1);
         a = (k % 2 == 0) ? 8'h0C : 8'h0D;
         d = (a == 8'h0C) ? gains(int'($urandom_range(0, 511)), (k % 4 == 0) ? 128 : int'($urandom_range(0, 511)))
                          : offsets(int'($signed(16'($urandom))), int'($signed(12'($urandom))));
         step(1'b1, int'($signed(16'($urandom))), int'($signed(16'($urandom))), w, a, d, "R8");
      end
      idle(3, "R8");

      // R3/R6 mix: random traffic, random gains with frequent unity
      for (int k = 0; k < 400; k++) begin
         bit w, v;
         int gi, gq;
         v  = ($urandom_range(0, 3) != 0);
         w  = ($urandom_range(0, 9) == 0);
         gi = ($urandom_range(0, 1) == 0) ? 128 : int'($urandom_range(0, 511));
         gq = ($urandom_range(0, 1) == 0) ? 128 : int'($urandom_range(0, 511));
         if (w && (k % 2 == 0))
            step(v, int'($signed(16'($urandom))), int'($signed(16'($urandom))), 1'b1, 8'h0C, gains(gi, gq), "R3");
         else if (w)
            step(v, int'($signed(16'($urandom))), int'($signed(16'($urandom))), 1'b1, 8'h0D,
                 offsets(int'($signed(14'($urandom))), int'($signed(14'($urandom)))), "R3");
         else
            step(v, int'($signed(16'($urandom))), int'($signed(16'($urandom))), 1'b0, 8'h00, 32'h0, "R6");
      end
      idle(4, "R7");
      finish_run();
   end
endmodule